// File: doc/BRIEF.md
# Watchdog Timer with Safe-Frequency Recovery

This block guards a system against a hang that follows a bad clock-frequency change. Host software programs an 8-bit timeout, in units of a slow time-base tick (nominally 250 ms per tick), and starts the timer. Each tick lowers the live count by one. If software does not restart or stop the timer before the count reaches zero, the block expires.

On expiry the block does three things. It sets a sticky timeout flag. It pulls an active-low open-drain system reset line low for a fixed number of ticks. It sends a single-cycle recovery pulse to the frequency selector, together with the 5-bit frequency code that the selector must return to. That code is the programmed safe code when safe reload is enabled, and otherwise the frequency code latched from the board straps. The same pulse tells the selector to leave divider-programmed (M/N) mode.

Generating the 250 ms time base and the frequency multiplexer itself lie outside this block.

Top module: `wdog_recover`

## Requirements
- R1: Reset gives count = 8 (programmed value 8), timeout flag 0, reset line released (`sys_rst_pull_n` = 1), `recover_pulse` 0, and `running` equal to the `strap_wd_en` level sampled during reset.
- R2: While `running` is 1, each `tick` with no host write in that cycle lowers `count` by one. The new value is visible from the cycle after the tick.
- R3: While `running` is 0, `tick` leaves `count` unchanged.
- R4: A tick that finds `running` = 1 and `count` at 1 or 0, with no host write in that cycle, expires the timer. From the next cycle `count` is 0, `running` is 0 and `tmo_flag` is 1. The flag has no host write path and stays 1 until the enable is next written with 1.
- R5: From the cycle after the expiring tick, `sys_rst_pull_n` is 0 (0 = pull the line low). It returns to 1 after RST_TICKS further ticks.
- R6: `recover_pulse` is 1 for exactly one cycle, in the cycle after the expiring tick. In that cycle `recover_code` equals `safe_code` if `safe_en` = 1, and `strap_fs` otherwise, both sampled at the expiring tick.
- R7: A write to the enable with value 1 sets `running` to 1, reloads `count` from the programmed value and clears `tmo_flag`. A write with value 0 clears `running` and keeps `count`.
- R8: A timeout write stores the value as the programmed value and loads it into `count` at once. If the timer is running, it keeps running from the new value.
- R9: A host write in the same cycle as a tick wins. That tick neither lowers the count nor expires the timer.
- R10: A programmed value of 0 expires the timer on the first tick after it is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_wd_en | input | 1 | Latched enable strap; sets the enable at reset |
| strap_fs | input | 5 | Latched strap frequency code |
| tick | input | 1 | One-cycle time-base pulse (one count step) |
| wr_en_stb | input | 1 | Host write strobe for the enable |
| wr_en_val | input | 1 | Enable value to write |
| wr_tmo_stb | input | 1 | Host write strobe for the timeout value |
| wr_tmo_val | input | 8 | Timeout value to write |
| safe_en | input | 1 | 1 = recover to the safe code, 0 = recover to the strap code |
| safe_code | input | 5 | Programmed safe frequency code |
| count | output | 8 | Live count (read-back of the timeout value) |
| running | output | 1 | 1 while counting (read-back of the enable) |
| tmo_flag | output | 1 | Sticky timeout status |
| sys_rst_pull_n | output | 1 | Open-drain reset drive; 0 = pull the line low |
| recover_pulse | output | 1 | One-cycle recovery request; also clears M/N mode |
| recover_code | output | 5 | Frequency code to reload |

## Verification
The expiring tick and a host restart can fall in the same cycle. The bench provokes this by running the count down to 1 and then raising `tick` together with an enable write of 1. It judges the result by the count reloading to the programmed value, the flag staying 0, and no recovery pulse or reset pull in the following cycles. A timeout write of 0 while running, followed by a single tick, checks the zero-value path and the strap-code selection in the same run.

// File: rtl/wdog_pkg.sv
// Package: shared sizes and defaults for the watchdog recovery block.
// Assumes: the frequency codes are 5 bits and the count is 8 bits wide.
package wdog_pkg;
    localparam int CNT_W_DEF   = 8;
    localparam int FS_W_DEF    = 5;
    localparam int DEF_TMO_DEF = 8;
    localparam int RST_TKS_DEF = 1;

    // Host request decoded for the counter
    typedef enum logic [1:0] {
        HOST_NONE,
        HOST_START,
        HOST_STOP,
        HOST_LOAD
    } host_op_e;
endpackage

// File: rtl/wdog_ctrl.sv
// Module: wdog_ctrl
// Holds the programmed timeout, the live count, the running state and the
// sticky timeout flag. It flags expiry for one cycle, combinationally, on the
// tick that ends the count.
// Assumes: a host write and a tick in the same cycle give the write priority.
module wdog_ctrl
    import wdog_pkg::*;
#(
    parameter int CNT_W   = CNT_W_DEF,
    parameter int DEF_TMO = DEF_TMO_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_wd_en,
    input  logic             tick,
    input  logic             wr_en_stb,
    input  logic             wr_en_val,
    input  logic             wr_tmo_stb,
    input  logic [CNT_W-1:0] wr_tmo_val,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             tmo_flag,
    output logic             expire
);
    localparam logic [CNT_W-1:0] RST_VAL = CNT_W'(DEF_TMO);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    logic [CNT_W-1:0] tmo_cfg;
    host_op_e         op;

    // Decode the host access; the enable write takes precedence over the timeout write
    always_comb begin
        if (wr_en_stb)       op = wr_en_val ? HOST_START : HOST_STOP;
        else if (wr_tmo_stb) op = HOST_LOAD;
        else                 op = HOST_NONE;
    end

    // Expiry: a tick reaching zero with no host access in the same cycle
    always_comb expire = tick && running && (count <= ONE) && (op == HOST_NONE);

    // Programmed timeout register
    always_ff @(posedge clk) begin
        if (!rst_n)          tmo_cfg <= RST_VAL;
        else if (wr_tmo_stb) tmo_cfg <= wr_tmo_val;
    end

    // Live count, running state and sticky flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count    <= RST_VAL;
            running  <= strap_wd_en;
            tmo_flag <= 1'b0;
        end else begin
            unique case (op)
                HOST_START: begin
                    count    <= wr_tmo_stb ? wr_tmo_val : tmo_cfg;
                    running  <= 1'b1;
                    tmo_flag <= 1'b0;
                end
                HOST_STOP: begin
                    running <= 1'b0;
                    if (wr_tmo_stb) count <= wr_tmo_val;
                end
                HOST_LOAD: count <= wr_tmo_val;
                default: begin
                    if (expire) begin
                        count    <= '0;
                        running  <= 1'b0;
                        tmo_flag <= 1'b1;
                    end else if (tick && running) begin
                        count <= count - ONE;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/wdog_rstgen.sv
// Module: wdog_rstgen
// Drives the open-drain reset pull for RST_TICKS tick periods after expiry.
// Assumes: expiry arrives on a tick cycle, so the hold starts with full periods.
module wdog_rstgen #(
    parameter int RST_TICKS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic expire,
    output logic pull_n
);
    localparam int PW = $clog2(RST_TICKS + 1);
    localparam logic [PW-1:0] LOAD = PW'(RST_TICKS);

    logic [PW-1:0] left;

    // Load the hold length on expiry and count it down on ticks
    always_ff @(posedge clk) begin
        if (!rst_n)                       left <= '0;
        else if (expire)                  left <= LOAD;
        else if (tick && left != '0)      left <= left - PW'(1);
    end

    // Pull the line low while the hold is active
    always_comb pull_n = (left == '0);
endmodule

// File: rtl/wdog_recover_sel.sv
// Module: wdog_recover_sel
// Registers a one-cycle recovery request and picks the frequency code to reload.
// Assumes: safe_en, safe_code and strap_fs are steady at the expiring tick.
module wdog_recover_sel #(
    parameter int FS_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            expire,
    input  logic            safe_en,
    input  logic [FS_W-1:0] safe_code,
    input  logic [FS_W-1:0] strap_fs,
    output logic            recover_pulse,
    output logic [FS_W-1:0] recover_code
);
    // Capture the request and its code on expiry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            recover_pulse <= 1'b0;
            recover_code  <= '0;
        end else begin
            recover_pulse <= expire;
            if (expire) recover_code <= safe_en ? safe_code : strap_fs;
        end
    end
endmodule

// File: rtl/wdog_recover.sv
// Module: wdog_recover (top)
// A watchdog that counts down in tick units and, on expiry, sets a sticky
// flag, pulls the system reset low and requests a frequency recovery.
// Assumes: tick is one cycle wide and is generated elsewhere.
module wdog_recover
    import wdog_pkg::*;
#(
    parameter int CNT_W     = CNT_W_DEF,
    parameter int FS_W      = FS_W_DEF,
    parameter int DEF_TMO   = DEF_TMO_DEF,
    parameter int RST_TICKS = RST_TKS_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_wd_en,
    input  logic [FS_W-1:0]  strap_fs,
    input  logic             tick,
    input  logic             wr_en_stb,
    input  logic             wr_en_val,
    input  logic             wr_tmo_stb,
    input  logic [CNT_W-1:0] wr_tmo_val,
    input  logic             safe_en,
    input  logic [FS_W-1:0]  safe_code,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             tmo_flag,
    output logic             sys_rst_pull_n,
    output logic             recover_pulse,
    output logic [FS_W-1:0]  recover_code
);
    logic expire;

    wdog_ctrl #(.CNT_W(CNT_W), .DEF_TMO(DEF_TMO)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .strap_wd_en(strap_wd_en), .tick(tick),
        .wr_en_stb(wr_en_stb), .wr_en_val(wr_en_val),
        .wr_tmo_stb(wr_tmo_stb), .wr_tmo_val(wr_tmo_val),
        .count(count), .running(running), .tmo_flag(tmo_flag), .expire(expire)
    );

    wdog_rstgen #(.RST_TICKS(RST_TICKS)) u_rst (
        .clk(clk), .rst_n(rst_n), .tick(tick), .expire(expire),
        .pull_n(sys_rst_pull_n)
    );

    wdog_recover_sel #(.FS_W(FS_W)) u_sel (
        .clk(clk), .rst_n(rst_n), .expire(expire), .safe_en(safe_en),
        .safe_code(safe_code), .strap_fs(strap_fs),
        .recover_pulse(recover_pulse), .recover_code(recover_code)
    );
endmodule

// File: rtl/wdog_recover_chk.sv
// Module: wdog_recover_chk
// Port-level properties of the watchdog, attached to the top by bind.
module wdog_recover_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             wr_en_stb,
    input logic             wr_en_val,
    input logic             wr_tmo_stb,
    input logic [CNT_W-1:0] count,
    input logic             running,
    input logic             tmo_flag,
    input logic             sys_rst_pull_n,
    input logic             recover_pulse
);
    logic quiet;
    always_comb quiet = !wr_en_stb && !wr_tmo_stb;

    a_r2_count_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && quiet && count > CNT_W'(1)) |=> (count == $past(count) - CNT_W'(1)));

    a_r3_idle_holds_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && quiet) |=> $stable(count));

    a_r4_expiry_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && quiet && count <= CNT_W'(1)) |=> (tmo_flag && !running && count == '0));

    a_r5_reset_pulled_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        recover_pulse |-> !sys_rst_pull_n);

    a_r6_recover_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        recover_pulse |=> !recover_pulse);

    a_r7_start_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_stb && wr_en_val) |=> (running && !tmo_flag));

    a_r9_write_beats_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !quiet) |=> !recover_pulse);
endmodule

bind wdog_recover wdog_recover_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en_stb(wr_en_stb),
    .wr_en_val(wr_en_val), .wr_tmo_stb(wr_tmo_stb), .count(count),
    .running(running), .tmo_flag(tmo_flag), .sys_rst_pull_n(sys_rst_pull_n),
    .recover_pulse(recover_pulse)
);

// File: tb/wdog_recover_bench.sv
// Directed bench for wdog_recover: one task per scenario, each checking itself.
module wdog_recover_bench;
    localparam int RT = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap_wd_en = 1'b0;
    logic [4:0] strap_fs = 5'h0A;
    logic       tick = 1'b0;
    logic       wr_en_stb = 1'b0, wr_en_val = 1'b0;
    logic       wr_tmo_stb = 1'b0;
    logic [7:0] wr_tmo_val = 8'd0;
    logic       safe_en = 1'b0;
    logic [4:0] safe_code = 5'h13;
    logic [7:0] count;
    logic       running, tmo_flag, sys_rst_pull_n, recover_pulse;
    logic [4:0] recover_code;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    wdog_recover #(.RST_TICKS(RT)) u_wdog_recover (
        .clk(clk), .rst_n(rst_n), .strap_wd_en(strap_wd_en), .strap_fs(strap_fs),
        .tick(tick), .wr_en_stb(wr_en_stb), .wr_en_val(wr_en_val),
        .wr_tmo_stb(wr_tmo_stb), .wr_tmo_val(wr_tmo_val), .safe_en(safe_en),
        .safe_code(safe_code), .count(count), .running(running),
        .tmo_flag(tmo_flag), .sys_rst_pull_n(sys_rst_pull_n),
        .recover_pulse(recover_pulse), .recover_code(recover_code)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic strap);
        strap_wd_en = strap;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic one_tick;
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic write_en(input logic v);
        wr_en_stb = 1'b1; wr_en_val = v;
        @(negedge clk);
        wr_en_stb = 1'b0;
    endtask

    task automatic write_tmo(input logic [7:0] v);
        wr_tmo_stb = 1'b1; wr_tmo_val = v;
        @(negedge clk);
        wr_tmo_stb = 1'b0;
    endtask

    task automatic t_reset_state;
        do_reset(1'b0);
        chk("R1 count", count, 8);
        chk("R1 running", running, 0);
        chk("R1 flag", tmo_flag, 0);
        chk("R1 rst pull", sys_rst_pull_n, 1);
        chk("R1 recover", recover_pulse, 0);
    endtask

    task automatic t_idle_ticks;
        repeat (3) one_tick();
        chk("R3 idle count", count, 8);
    endtask

    task automatic t_countdown;
        write_en(1'b1);
        chk("R7 running", running, 1);
        chk("R7 count", count, 8);
        repeat (3) one_tick();
        chk("R2 count after 3", count, 5);
    endtask

    task automatic t_expire_safe;
        safe_en = 1'b1;
        repeat (4) one_tick();
        chk("R2 count at 1", count, 1);
        one_tick();
        chk("R4 flag", tmo_flag, 1);
        chk("R4 running", running, 0);
        chk("R4 count", count, 0);
        chk("R5 pull low", sys_rst_pull_n, 0);
        chk("R6 pulse", recover_pulse, 1);
        chk("R6 safe code", recover_code, 'h13);
        @(negedge clk);
        chk("R6 pulse one cycle", recover_pulse, 0);
        chk("R4 flag sticky", tmo_flag, 1);
        one_tick();
        chk("R5 still low", sys_rst_pull_n, 0);
        one_tick();
        chk("R5 released", sys_rst_pull_n, 1);
    endtask

    task automatic t_restart_stop;
        write_en(1'b1);
        chk("R4 flag cleared on start", tmo_flag, 0);
        chk("R7 reload", count, 8);
        one_tick();
        write_en(1'b0);
        chk("R7 stopped", running, 0);
        one_tick();
        chk("R7 count kept", count, 7);
    endtask

    task automatic t_tmo_write;
        write_en(1'b1);
        one_tick();
        write_tmo(8'd3);
        chk("R8 count loaded", count, 3);
        chk("R8 still running", running, 1);
        one_tick();
        chk("R8 counts from new", count, 2);
    endtask

    task automatic t_collision;
        one_tick();
        chk("R9 count at 1", count, 1);
        tick = 1'b1; wr_en_stb = 1'b1; wr_en_val = 1'b1;
        @(negedge clk);
        tick = 1'b0; wr_en_stb = 1'b0;
        chk("R9 reload wins", count, 3);
        chk("R9 no flag", tmo_flag, 0);
        chk("R9 no pull", sys_rst_pull_n, 1);
        chk("R9 no recover", recover_pulse, 0);
    endtask

    task automatic t_zero;
        safe_en = 1'b0;
        write_tmo(8'd0);
        chk("R10 count zero", count, 0);
        chk("R10 running", running, 1);
        one_tick();
        chk("R10 expired", tmo_flag, 1);
        chk("R6 strap code", recover_code, 'h0A);
        chk("R6 pulse", recover_pulse, 1);
        repeat (RT) one_tick();
        chk("R5 released after zero", sys_rst_pull_n, 1);
    endtask

    task automatic t_strap_on;
        do_reset(1'b1);
        chk("R1 strap running", running, 1);
        one_tick();
        chk("R1 strap counts", count, 7);
    endtask

    initial begin
        fork
            begin
                t_reset_state();
                t_idle_ticks();
                t_countdown();
                t_expire_safe();
                t_restart_stop();
                t_tmo_write();
                t_collision();
                t_zero();
                t_strap_on();
            end
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog: actual=hung expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule